// File: doc/BRIEF.md
# Target Configuration Pin Sequencer

This block puts an external programmable device into a clean state, ready to receive a configuration image, by working its three configuration pins. After a one-cycle request from the host side, it drives the active-low program-request pin low and waits until the target pulls its active-low init pin low. It also waits until the target's active-high done pin reads low. It then lets program-request return high and waits for init to return high. That last level tells the host that loading the image may begin.

The pins are sampled at a fixed poll period in microseconds. The microsecond tick comes from dividing the block clock by a parameter. Every wait is bounded. If a wait runs past the timeout, the sequence stops, program-request returns high and an error flag is raised. The host sees `busy_o` for the whole sequence, then either a one-cycle `ready_o` pulse or a held `err_o`.

Top module: `cfg_pin_sequencer`

## Requirements
- R1: After reset `prog_n_o` is 1 and `busy_o`, `ready_o` and `err_o` are 0.
- R2: A cycle with `start_i` high while idle makes `busy_o` 1 and `prog_n_o` 0 from the next cycle on, and clears `err_o` in that same cycle.
- R3: Pins are compared only at poll instants. A poll instant falls every POLL_US microseconds (one microsecond is CLK_PER_US clocks), counted from the edge that entered the current wait. In the first wait the block moves on at the first poll that sees `init_n_i` low.
- R4: In the second wait, `prog_n_o` stays 0 and the block moves on at the first poll that sees `done_i` low.
- R5: The third wait starts with `prog_n_o` at 1. At the first poll that sees `init_n_i` high, the block drops `busy_o` and raises `ready_o` for exactly one cycle. If the target answers at once, `ready_o` is seen 3*POLL_US*CLK_PER_US clocks after the start edge.
- R6: A wait that has not moved on after TIMEOUT_US microseconds ends the sequence: `busy_o` goes to 0, `prog_n_o` to 1 and `err_o` to 1. A poll on that same edge that sees the expected level wins over the timeout. `prog_n_o` is 0 only while `busy_o` is 1.
- R7: `err_o` stays 1 until the next accepted start.
- R8: `start_i` while busy has no effect on the sequence or its timing.
- R9: `init_n_i` and `done_i` each pass through two flops before comparison, so a poll does not see a change made in the cycle just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sequence request pulse |
| init_n_i | input | 1 | Target init pin, active low, asynchronous |
| done_i | input | 1 | Target done pin, active high, asynchronous |
| prog_n_o | output | 1 | Target program-request pin, active low |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | One-cycle pulse when the target is ready to load |
| err_o | output | 1 | A wait timed out; held until the next start |

## Verification
The target is modelled with pin responses placed at chosen cycles after the start. Scenarios:
- An immediate answer gives the shortest latency, which confirms the poll pacing.
- Answers delayed past one poll, and a done pin that drops late, show that each wait repeats on the poll grid and does not react between polls.
- A pin change placed one cycle and two cycles before a poll separates the synchroniser depth.
- Pins that never answer in each of the three waits give timeout latencies that identify which wait counter ran.
- A response that lands exactly on the timeout poll shows that a match wins over the timeout.
- A second start in mid-sequence confirms that requests while busy are ignored.

// File: rtl/cfg_pin_sequencer.sv
module cfg_pin_sequencer #(
  parameter int CLK_PER_US = 100,
  parameter int POLL_US    = 30,
  parameter int TIMEOUT_US = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic init_n_i,
  input  logic done_i,
  output logic prog_n_o,
  output logic busy_o,
  output logic ready_o,
  output logic err_o
);

  localparam int DIV_W  = $clog2(CLK_PER_US + 1);
  localparam int POLL_W = $clog2(POLL_US + 1);
  localparam int TO_W   = $clog2(TIMEOUT_US + 1);
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(CLK_PER_US - 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_US - 1);
  localparam logic [TO_W-1:0]   TO_LAST   = TO_W'(TIMEOUT_US - 1);

  typedef enum logic [1:0] {S_IDLE, S_HOLD_INIT, S_HOLD_DONE, S_RELEASE} st_t;
  st_t st;

  logic [1:0] init_sync, done_sync;
  logic [DIV_W-1:0]  div_cnt;
  logic [POLL_W-1:0] poll_cnt;
  logic [TO_W-1:0]   wait_us;
  logic init_s, done_s, us_tick, poll_hit, to_hit, want_met, advance, expire, restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_sync <= 2'b11;
      done_sync <= 2'b00;
    end else begin
      init_sync <= {init_sync[0], init_n_i};
      done_sync <= {done_sync[0], done_i};
    end
  end

  assign init_s   = init_sync[1];
  assign done_s   = done_sync[1];
  assign us_tick  = (div_cnt == DIV_LAST);
  assign poll_hit = us_tick && (poll_cnt == POLL_LAST);
  assign to_hit   = us_tick && (wait_us == TO_LAST);

  always_comb begin
    case (st)
      S_HOLD_INIT: want_met = !init_s;
      S_HOLD_DONE: want_met = !done_s;
      S_RELEASE:   want_met = init_s;
      default:     want_met = 1'b0;
    endcase
  end

  assign advance = (st != S_IDLE) && poll_hit && want_met;
  assign expire  = (st != S_IDLE) && to_hit && !advance;
  assign restart = ((st == S_IDLE) && start_i) || advance;
  assign busy_o  = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      poll_cnt <= '0;
      wait_us  <= '0;
    end else if (restart || st == S_IDLE) begin
      div_cnt  <= '0;
      poll_cnt <= '0;
      wait_us  <= '0;
    end else begin
      div_cnt <= us_tick ? '0 : div_cnt + 1'b1;
      if (us_tick) begin
        poll_cnt <= poll_hit ? '0 : poll_cnt + 1'b1;
        wait_us  <= wait_us + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      prog_n_o <= 1'b1;
      ready_o  <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      ready_o <= 1'b0;
      if (expire) begin
        st       <= S_IDLE;
        prog_n_o <= 1'b1;
        err_o    <= 1'b1;
      end else begin
        case (st)
          S_IDLE: if (start_i) begin
            st       <= S_HOLD_INIT;
            prog_n_o <= 1'b0;
            err_o    <= 1'b0;
          end
          S_HOLD_INIT: if (advance) st <= S_HOLD_DONE;
          S_HOLD_DONE: if (advance) begin
            st       <= S_RELEASE;
            prog_n_o <= 1'b1;
          end
          S_RELEASE: if (advance) begin
            st      <= S_IDLE;
            ready_o <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !prog_n_o && !err_o));

  assert_hold_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD_DONE) |-> !prog_n_o);

  assert_ready_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);

  assert_ready_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (!busy_o && prog_n_o && !err_o));

  assert_prog_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> prog_n_o);

  assert_end_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (ready_o ^ err_o));

  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !(start_i && !busy_o)) |=> err_o);

endmodule

// File: tb/tb_cfg_pin_sequencer.sv
module tb_cfg_pin_sequencer;
  localparam int CPU = 4;
  localparam int PU  = 3;
  localparam int TU  = 15;
  localparam int PC  = PU * CPU;
  localparam int TC  = TU * CPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic init_n = 1'b1;
  logic done = 1'b1;
  logic prog_n, busy, ready, err;
  int total = 0;
  int fails = 0;
  logic pn_log [0:199];
  logic bs_log [0:199];
  logic er_log [0:199];
  int   end_n;
  logic end_err;

  always #5 clk = ~clk;

  cfg_pin_sequencer #(.CLK_PER_US(CPU), .POLL_US(PU), .TIMEOUT_US(TU)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .init_n_i(init_n), .done_i(done),
    .prog_n_o(prog_n), .busy_o(busy), .ready_o(ready), .err_o(err));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_seq(input int ti_lo, input int td_lo, input int ti_hi, input int again_n);
    int n;
    bit seen;
    init_n = 1'b1;
    done   = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    seen = 0;
    end_err = 1'b0;
    while (!seen && n < 199) begin
      pn_log[n] = prog_n;
      bs_log[n] = busy;
      er_log[n] = err;
      if (ready || err) begin
        seen = 1;
        end_err = err;
      end else begin
        if (n == ti_lo) init_n = 1'b0;
        if (n == td_lo) done = 1'b0;
        if (n == ti_hi) init_n = 1'b1;
        start = (n == again_n);
        @(negedge clk);
        n++;
      end
    end
    start = 1'b0;
    end_n = seen ? n : -1;
  endtask

  task automatic t_reset;
    check(prog_n === 1'b1, "R1 prog_n after reset", prog_n, 1);
    check(busy === 1'b0 && ready === 1'b0 && err === 1'b0, "R1 flags after reset",
          {busy, ready, err}, 0);
  endtask

  task automatic t_nominal;
    run_seq(0, 0, 26, -1);
    check(bs_log[0] === 1'b1 && pn_log[0] === 1'b0 && er_log[0] === 1'b0,
          "R2 busy and prog low after start", {bs_log[0], pn_log[0], er_log[0]}, 4);
    check(end_n == 3 * PC && !end_err, "R5 ready latency, immediate target", end_n, 3 * PC);
    check(pn_log[PC + 5] === 1'b0, "R4 prog held low in second wait", pn_log[PC + 5], 0);
    check(pn_log[2 * PC - 1] === 1'b0 && pn_log[2 * PC] === 1'b1,
          "R5 prog released at third wait", {pn_log[2 * PC - 1], pn_log[2 * PC]}, 1);
    @(negedge clk);
    check(ready === 1'b0 && busy === 1'b0 && prog_n === 1'b1, "R5 ready is one cycle",
          {ready, busy, prog_n}, 1);
  endtask

  task automatic t_slow_init;
    run_seq(18, 18, 40, -1);
    check(end_n == 4 * PC && !end_err, "R3 late init waits for next poll", end_n, 4 * PC);
  endtask

  task automatic t_sync_depth;
    run_seq(PC - 2, 0, 37, -1);
    check(end_n == 4 * PC && !end_err, "R9 change one cycle before poll missed", end_n, 4 * PC);
    run_seq(PC - 3, 0, 26, -1);
    check(end_n == 3 * PC && !end_err, "R9 change two cycles before poll seen", end_n, 3 * PC);
  endtask

  task automatic t_done_late;
    run_seq(0, 30, 38, -1);
    check(end_n == 4 * PC && !end_err, "R4 done high holds second wait", end_n, 4 * PC);
    check(pn_log[30] === 1'b0, "R4 prog low while done high", pn_log[30], 0);
  endtask

  task automatic t_timeout_first;
    run_seq(-1, -1, -1, -1);
    check(end_n == TC && end_err, "R6 timeout in first wait", end_n, TC);
    check(bs_log[TC - 1] === 1'b1, "R6 busy until timeout", bs_log[TC - 1], 1);
    check(pn_log[end_n] === 1'b1 && bs_log[end_n] === 1'b0, "R6 prog released on timeout",
          {pn_log[end_n], bs_log[end_n]}, 2);
  endtask

  task automatic t_timeout_second;
    run_seq(0, -1, -1, -1);
    check(end_n == PC + TC && end_err, "R6 timeout in second wait", end_n, PC + TC);
  endtask

  task automatic t_timeout_third;
    run_seq(0, 0, -1, -1);
    check(end_n == 2 * PC + TC && end_err, "R6 timeout in third wait", end_n, 2 * PC + TC);
    check(pn_log[end_n] === 1'b1, "R6 prog high after third-wait timeout", pn_log[end_n], 1);
  endtask

  task automatic t_tie;
    run_seq(TC - 3, 0, TC + 14, -1);
    check(end_n == TC + 2 * PC && !end_err, "R6 match on timeout poll wins", end_n, TC + 2 * PC);
  endtask

  task automatic t_err_hold;
    run_seq(-1, -1, -1, -1);
    init_n = 1'b0;
    done = 1'b0;
    repeat (10) @(negedge clk);
    check(err === 1'b1 && busy === 1'b0 && prog_n === 1'b1, "R7 error held while idle",
          {err, busy, prog_n}, 5);
    run_seq(0, 0, 26, -1);
    check(er_log[0] === 1'b0, "R7 error cleared by next start", er_log[0], 0);
  endtask

  task automatic t_restart_ignored;
    run_seq(0, 0, 26, 5);
    check(end_n == 3 * PC && !end_err, "R8 start while busy ignored", end_n, 3 * PC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_nominal();
    t_slow_init();
    t_sync_depth();
    t_done_late();
    t_timeout_first();
    t_timeout_second();
    t_timeout_third();
    t_tie();
    t_err_hold();
    t_restart_ignored();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #200000;
    total++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule